// File: doc/BRIEF.md
# Sector Stream CRC Integrity Gate

This block sits in a byte stream between a storage device and a host. Each unit it carries is one storage sector: a fixed number of payload bytes followed at once by a 16-bit CRC. The gate stores a whole unit and checks its CRC over all of its bytes. If the check passes, the gate runs the payload through a keyed transform and sends it on with a freshly computed CRC. The transform here is a 128-bit key XOR, which stands in for a real cipher. If the check fails, the gate sends the unit on exactly as it arrived, so that the receiver sees the CRC error and asks for the sector again.

The caller marks each unit with two flags, both taken with the last input byte of the unit. One flag gives the transfer direction, which picks the order in which key bytes are applied. The other is a digest verdict. When the verdict is "bad", the gate deliberately spoils the final output byte, so a unit that would otherwise be accepted is rejected downstream. Both the input and the output are byte-wide valid/ready streams. The output honours back-pressure.

Top module: `sector_crc_gate`

## Requirements
- R1: A unit is SECTOR_BYTES payload bytes followed by a 16-bit CRC sent high byte first. The CRC is CRC-16 with polynomial 0x1021, initial value 0, data fed most significant bit first. A unit passes its check when the CRC run over all SECTOR_BYTES+2 bytes leaves a zero remainder.
- R2: No output byte appears before the last byte of the unit has been accepted. The first output byte is valid in the cycle after that acceptance, and in_ready stays low while the unit is being emitted.
- R3: On a passing unit, output payload byte i is input payload byte i XOR key byte j, where key byte j is key[8j+7:8j]. With in_dir=0, j = i mod 16. With in_dir=1, j = 15 - (i mod 16). in_dir is taken with the last input byte.
- R4: On a passing unit, the two bytes after the payload are the R1 CRC of the transformed output payload, high byte first.
- R5: On a failing unit, all SECTOR_BYTES+2 bytes come out unchanged, including the original CRC bytes.
- R6: On a passing unit, in_digest_bad=1 (taken with the last input byte) inverts all eight bits of the final output byte and changes no other byte. On a failing unit, in_digest_bad has no effect.
- R7: out_last is high on the final byte of each unit and on no other byte.
- R8: While out_valid is high and out_ready is low, out_valid stays high and out_data stays unchanged. No byte is lost or repeated.
- R9: After reset, in_ready is 1 and out_valid is 0.
- R10: After the handshake of the final output byte, in_ready is 1 and out_valid is 0 in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| key | input | KEY_W | Transform key |
| in_valid | input | 1 | Input byte valid |
| in_ready | output | 1 | Gate can accept an input byte |
| in_data | input | 8 | Input byte |
| in_dir | input | 1 | Direction select, taken with the last byte of a unit |
| in_digest_bad | input | 1 | Digest verdict, taken with the last byte of a unit |
| out_valid | output | 1 | Output byte valid |
| out_ready | input | 1 | Downstream accepts the output byte |
| out_data | output | 8 | Output byte |
| out_last | output | 1 | Marks the final byte of a unit |

## Verification
Suppose the byte index or the phase state went wrong. The unit would then end early or late: out_last would fall on the wrong byte, or in_ready would fail to come back the cycle after the final handshake. Both show up within one unit. A receive remainder that was not cleared between units would make the next good unit take the pass-through path, so every payload byte would miss its key XOR from the first output byte on. A wrong key-byte order or an error in the output CRC leaves framing intact but changes the payload or the two trailing bytes, so the bench compares every emitted byte against values computed independently.

// File: rtl/sg_pkg.sv
package sg_pkg;

   typedef enum logic {
      ST_FILL = 1'b0,
      ST_SEND = 1'b1
   } sg_phase_e;

   localparam logic [15:0] SG_CRC_POLY = 16'h1021;

   // One byte of CRC-16 with the data fed most significant bit first
   function automatic logic [15:0] sg_crc_step(input logic [15:0] c, input logic [7:0] d);
      logic [15:0] r;
      r = c;
      for (int b = 7; b >= 0; b--) begin
         if (r[15] ^ d[b]) r = (r << 1) ^ SG_CRC_POLY;
         else              r = r << 1;
      end
      return r;
   endfunction

endpackage

// File: rtl/sg_crc16.sv
module sg_crc16 (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        clr,
   input  logic        en,
   input  logic [7:0]  data,
   output logic [15:0] crc
);
   import sg_pkg::*;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   crc <= '0;
      else if (clr) crc <= '0;
      else if (en)  crc <= sg_crc_step(crc, data);
   end

   AST_CLEAR_TO_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      clr |=> crc == 16'h0000); // R1

endmodule

// File: rtl/sg_sector_buf.sv
module sg_sector_buf #(
   parameter int DEPTH = 514,
   parameter int AW    = $clog2(DEPTH)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          we,
   input  logic [AW-1:0] waddr,
   input  logic [7:0]    wdata,
   input  logic [AW-1:0] raddr,
   output logic [7:0]    rdata
);
   generate
      if (DEPTH < 3) begin : g_bad_depth
         $error("sg_sector_buf: DEPTH must be at least 3");
      end
      if ((1 << AW) < DEPTH) begin : g_bad_aw
         $error("sg_sector_buf: AW too narrow for DEPTH");
      end
   endgenerate

   logic [7:0] mem [DEPTH];

   always_ff @(posedge clk) begin
      if (we) mem[waddr] <= wdata;
   end

   assign rdata = mem[raddr];

   AST_WADDR_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
      we |-> int'(waddr) < DEPTH); // R1

endmodule

// File: rtl/sg_keyxor.sv
module sg_keyxor #(
   parameter int KEY_W     = 128,
   parameter int KEY_BYTES = KEY_W / 8,
   parameter int KPW       = $clog2(KEY_BYTES)
) (
   input  logic [KEY_W-1:0] key,
   input  logic [KPW-1:0]   pos,
   input  logic             dir,
   input  logic [7:0]       din,
   output logic [7:0]       dout
);
   generate
      if (KEY_W % 8 != 0) begin : g_bad_kw
         $error("sg_keyxor: KEY_W must be a multiple of 8");
      end
      if (KEY_BYTES < 2 || (1 << KPW) != KEY_BYTES) begin : g_bad_kb
         $error("sg_keyxor: key byte count must be a power of two, at least 2");
      end
   endgenerate

   logic [7:0] kbyte [KEY_BYTES];

   for (genvar g = 0; g < KEY_BYTES; g++) begin : g_kb
      assign kbyte[g] = key[8*g +: 8];
   end

   // Host-to-storage walks the key from the top byte down
   logic [KPW-1:0] sel;
   assign sel  = dir ? ~pos : pos;
   assign dout = din ^ kbyte[sel];

endmodule

// File: rtl/sector_crc_gate.sv
module sector_crc_gate #(
   parameter int SECTOR_BYTES = 512,
   parameter int KEY_W        = 128
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [KEY_W-1:0] key,
   input  logic             in_valid,
   output logic             in_ready,
   input  logic [7:0]       in_data,
   input  logic             in_dir,
   input  logic             in_digest_bad,
   output logic             out_valid,
   input  logic             out_ready,
   output logic [7:0]       out_data,
   output logic             out_last
);
   import sg_pkg::*;

   localparam int TOTAL     = SECTOR_BYTES + 2;
   localparam int IW        = $clog2(TOTAL);
   localparam int KEY_BYTES = KEY_W / 8;
   localparam int KPW       = $clog2(KEY_BYTES);

   generate
      if (SECTOR_BYTES < 1) begin : g_bad_sector
         $error("sector_crc_gate: SECTOR_BYTES must be positive");
      end
      if (KPW > IW) begin : g_bad_key_vs_sector
         $error("sector_crc_gate: key longer than the unit");
      end
   endgenerate

   sg_phase_e      phase;
   logic [IW-1:0]  idx;
   logic           dir_q, bad_q;
   logic           acc, fire, at_end, in_payload, crc_ok;
   logic [7:0]     raw, xf, od;
   logic [15:0]    rx_crc, tx_crc;

   assign in_ready   = (phase == ST_FILL);
   assign out_valid  = (phase == ST_SEND);
   assign acc        = in_valid && in_ready;
   assign fire       = out_valid && out_ready;
   assign at_end     = (idx == IW'(TOTAL - 1));
   assign in_payload = (idx < IW'(SECTOR_BYTES));
   assign crc_ok     = (rx_crc == 16'h0000);

   sg_sector_buf #(.DEPTH(TOTAL), .AW(IW)) u_buf (
      .clk(clk), .rst_n(rst_n),
      .we(acc), .waddr(idx), .wdata(in_data),
      .raddr(idx), .rdata(raw)
   );

   // Receive remainder stays put through emission, cleared at unit end
   sg_crc16 u_rx_crc (
      .clk(clk), .rst_n(rst_n),
      .clr(fire && at_end), .en(acc), .data(in_data), .crc(rx_crc)
   );

   sg_keyxor #(.KEY_W(KEY_W)) u_xor (
      .key(key), .pos(idx[KPW-1:0]), .dir(dir_q), .din(raw), .dout(xf)
   );

   always_comb begin
      if (!crc_ok)                         od = raw;
      else if (in_payload)                 od = xf;
      else if (idx == IW'(SECTOR_BYTES))   od = tx_crc[15:8];
      else                                 od = tx_crc[7:0] ^ {8{bad_q}};
   end

   sg_crc16 u_tx_crc (
      .clk(clk), .rst_n(rst_n),
      .clr(fire && at_end), .en(fire && in_payload), .data(od), .crc(tx_crc)
   );

   assign out_data = od;
   assign out_last = out_valid && at_end;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase <= ST_FILL;
         idx   <= '0;
         dir_q <= 1'b0;
         bad_q <= 1'b0;
      end else if (phase == ST_FILL) begin
         if (acc) begin
            if (at_end) begin
               phase <= ST_SEND;
               idx   <= '0;
               dir_q <= in_dir;
               bad_q <= in_digest_bad;
            end else begin
               idx <= idx + 1'b1;
            end
         end
      end else if (fire) begin
         if (at_end) begin
            phase <= ST_FILL;
            idx   <= '0;
         end else begin
            idx <= idx + 1'b1;
         end
      end
   end

   AST_HOLD_UNDER_STALL: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid && !out_ready |=> out_valid && $stable(out_data)); // R8

   AST_REOPEN_AFTER_LAST: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid && out_ready && out_last |=> in_ready && !out_valid); // R10

   AST_SEND_AFTER_FILL: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid && in_ready && at_end |=> out_valid && !in_ready); // R2

endmodule

// File: tb/sim_sector_crc_gate.sv
module sim_sector_crc_gate;
   localparam int NB  = 512;
   localparam int TOT = NB + 2;
   localparam logic [127:0] KEY = 128'h0F1E2D3C_4B5A6978_8796A5B4_C3D2E1F0;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       in_valid = 1'b0, in_dir = 1'b0, in_digest_bad = 1'b0, out_ready = 1'b0;
   logic [7:0] in_data = '0;
   logic       in_ready, out_valid, out_last;
   logic [7:0] out_data;

   always #4 clk = ~clk;

   sector_crc_gate #(.SECTOR_BYTES(NB), .KEY_W(128)) u0 (
      .clk(clk), .rst_n(rst_n), .key(KEY),
      .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
      .in_dir(in_dir), .in_digest_bad(in_digest_bad),
      .out_valid(out_valid), .out_ready(out_ready),
      .out_data(out_data), .out_last(out_last)
   );

   int checks = 0;
   int errors = 0;
   logic [7:0] frame [TOT];
   logic [7:0] expv  [TOT];

   function automatic logic [15:0] ref_crc(input logic [15:0] c, input logic [7:0] d);
      logic [15:0] r;
      r = c;
      for (int b = 7; b >= 0; b--)
         r = (r[15] ^ d[b]) ? ((r << 1) ^ 16'h1021) : (r << 1);
      return r;
   endfunction

   task automatic check(input bit ok, input string req, input string what,
                        input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   // pat 0: incrementing, pat 1: LFSR. corrupt_at >= 0 flips a bit there.
   task automatic build(input int pat, input int corrupt_at);
      logic [15:0] c;
      logic [7:0]  s;
      s = 8'hA5;
      c = 16'h0;
      for (int i = 0; i < NB; i++) begin
         if (pat == 0) frame[i] = 8'(i);
         else begin
            s = {s[6:0], s[7] ^ s[5] ^ s[4] ^ s[3]};
            frame[i] = s;
         end
         c = ref_crc(c, frame[i]);
      end
      frame[NB]   = c[15:8];
      frame[NB+1] = c[7:0];
      if (corrupt_at >= 0) frame[corrupt_at] = frame[corrupt_at] ^ 8'h40;
   endtask

   task automatic expect_out(input bit dir, input bit bad, input bit good);
      logic [15:0] c;
      int j;
      c = 16'h0;
      for (int i = 0; i < TOT; i++) expv[i] = frame[i];
      if (good) begin
         for (int i = 0; i < NB; i++) begin
            j = dir ? 15 - (i % 16) : i % 16;
            expv[i] = frame[i] ^ KEY[8*j +: 8];
            c = ref_crc(c, expv[i]);
         end
         expv[NB]   = c[15:8];
         expv[NB+1] = c[7:0] ^ (bad ? 8'hFF : 8'h00);
      end
   endtask

   task automatic run_unit(input bit dir, input bit bad, input bit stall, input string req);
      int first_bad, bad_cnt, last_err, stall_err;
      logic [7:0] hold;
      logic [7:0] got;
      first_bad = -1; bad_cnt = 0; last_err = 0; stall_err = 0;
      for (int i = 0; i < TOT; i++) begin
         @(negedge clk);
         in_valid = 1'b1; in_data = frame[i]; in_dir = dir; in_digest_bad = bad;
         if (i == TOT - 1)
            check(!out_valid && in_ready, "R2", "no output before unit complete", out_valid, 0);
         @(posedge clk);
      end
      @(negedge clk);
      in_valid = 1'b0; in_dir = 1'b0; in_digest_bad = 1'b0;
      check(out_valid && !in_ready, "R2", "first byte valid one cycle after fill", out_valid, 1);
      for (int k = 0; k < TOT; k++) begin
         if (stall && (k % 5 == 2)) begin
            out_ready = 1'b0;
            hold = out_data;
            @(negedge clk);
            if (!out_valid || out_data !== hold) stall_err++;
         end
         out_ready = 1'b1;
         got = out_data;
         if (!out_valid || got !== expv[k]) begin
            bad_cnt++;
            if (first_bad < 0) first_bad = k;
         end
         if (out_last !== (k == TOT - 1)) last_err++;
         @(posedge clk);
         @(negedge clk);
         out_ready = 1'b0;
      end
      if (first_bad >= 0)
         check(1'b0, req, $sformatf("byte %0d value", first_bad),
               int'(out_data), int'(expv[first_bad]));
      else check(1'b1, req, "all bytes", 0, 0);
      check(last_err == 0, "R7", "out_last position errors", last_err, 0);
      if (stall) check(stall_err == 0, "R8", "stall hold violations", stall_err, 0);
      check(in_ready && !out_valid, "R10", "input reopens after final byte", in_ready, 1);
   endtask

   task automatic t_reset;
      check(in_ready === 1'b1, "R9", "in_ready after reset", in_ready, 1);
      check(out_valid === 1'b0, "R9", "out_valid after reset", out_valid, 0);
   endtask

   task automatic t_pass_dir0;   // R1 R3 R4
      build(0, -1); expect_out(1'b0, 1'b0, 1'b1);
      run_unit(1'b0, 1'b0, 1'b0, "R3/R4 pass dir0");
   endtask

   task automatic t_pass_dir1;   // R3 R4
      build(1, -1); expect_out(1'b1, 1'b0, 1'b1);
      run_unit(1'b1, 1'b0, 1'b0, "R3/R4 pass dir1");
   endtask

   task automatic t_fail_payload;   // R5, and R6 verdict ignored on failing unit
      build(0, 100); expect_out(1'b0, 1'b1, 1'b0);
      run_unit(1'b0, 1'b1, 1'b0, "R5/R6 fail passthrough verdict ignored");
   endtask

   task automatic t_fail_crcbyte;   // R5
      build(1, NB + 1); expect_out(1'b1, 1'b0, 1'b0);
      run_unit(1'b1, 1'b0, 1'b0, "R5 bad CRC byte passthrough");
   endtask

   task automatic t_digest_bad;   // R6 with stalls R8
      build(1, -1); expect_out(1'b0, 1'b1, 1'b1);
      run_unit(1'b0, 1'b1, 1'b1, "R6 digest bad final byte");
   endtask

   task automatic t_backpressure;   // R8
      build(0, -1); expect_out(1'b1, 1'b0, 1'b1);
      run_unit(1'b1, 1'b0, 1'b1, "R8 backpressure dir1");
   endtask

   initial begin
      repeat (3) @(posedge clk);
      @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_pass_dir0();
      t_pass_dir1();
      t_fail_payload();
      t_fail_crcbyte();
      t_digest_bad();
      t_backpressure();
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule